// File: doc/BRIEF.md
# I2C Master Byte Queues and Interrupt Status

This unit sits between the register front end of an I2C master and its bus engine. It holds two byte queues. Software writes outgoing bytes into the transmit queue and the engine pulls them. The engine pushes incoming bytes into the receive queue and software pops them. Byte ports on both sides move data in a single cycle. A software push is a write strobe with data. A software pop is a read strobe, and the head byte is presented combinationally in the same cycle. The engine uses a pull/valid pair and a push/ready pair.

The unit also builds a 32-bit raw interrupt status word. Queue occupancy levels and programmable thresholds drive some of its bits. Other bits are sticky event flags: transmit overrun, transaction done, done without stop, arbitration lost and bus error. A mask register, a write-one-to-clear input and a masked status word complete the interrupt path, and any set masked bit drives the interrupt line. Each queue has its own flush request. A flush empties that queue and then keeps a busy flag high for a fixed number of cycles before the flag drops by itself.

Top module: `i2c_fifo_irq`

## Requirements
- R1: After reset both queues are empty, all sticky flags and the mask are zero, the interrupt line is low and both flush busy flags are low.
- R2: Bytes leave each queue in the order they entered, and each queue holds up to DEPTH bytes (DEPTH is a power of two, 16 by default).
- R3: Transmit level bits follow the transmit count: bit 0 is set when the count is 0, bit 2 is set when the count is DEPTH, and bit 1 is set when the count is at most the effective transmit threshold.
- R4: Receive level bits follow the receive count: bit 4 is set when the count is 0, bit 6 is set when the count is DEPTH, and bit 5 is set when the count is at least the effective receive threshold.
- R5: A threshold input larger than DEPTH/2-1 acts as DEPTH/2-1 (7 for a depth of 16).
- R6: A software push while the transmit queue is full is dropped and sets sticky bit 3.
- R7: A software pop of an empty receive queue returns 0x00 and changes nothing. An engine pull of an empty transmit queue changes nothing and presents 0x00 with valid low. An engine push into a full receive queue is dropped, and ready is low while the queue is full.
- R8: Pulses on the done, done-without-stop, arbitration-lost and bus-error inputs set sticky bits 19, 28, 24 and 25. These bits stay set until they are cleared.
- R9: A clear write with a 1 in a position of 0x131F007F clears that sticky bit. An event arriving in the same cycle wins over the clear. Level bits are not affected by a clear.
- R10: The masked status equals the raw status ANDed with the mask, with mask bits 31:29 always held at 0. The interrupt line is high exactly when the masked status is nonzero.
- R11: A flush request empties its queue at the next edge and raises that queue's busy flag for FLUSH_CYC cycles (4 by default). While the flag is high, pushes and pops on that queue are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_tx_wr | input | 1 | Software push into the transmit queue |
| sw_tx_data | input | 8 | Byte pushed by software |
| sw_rx_rd | input | 1 | Software pop from the receive queue |
| sw_rx_data | output | 8 | Receive head byte, 0x00 when empty |
| eng_tx_pull | input | 1 | Engine takes the transmit head byte |
| eng_tx_data | output | 8 | Transmit head byte, 0x00 when empty |
| eng_tx_valid | output | 1 | Transmit queue holds a byte |
| eng_rx_push | input | 1 | Engine pushes a received byte |
| eng_rx_data | input | 8 | Byte pushed by the engine |
| eng_rx_ready | output | 1 | Receive queue can accept a byte |
| tx_thr | input | 8 | Transmit nearly-empty threshold |
| rx_thr | input | 8 | Receive nearly-full threshold |
| flush_tx_req | input | 1 | Start a transmit flush |
| flush_rx_req | input | 1 | Start a receive flush |
| flush_tx_busy | output | 1 | Transmit flush in progress |
| flush_rx_busy | output | 1 | Receive flush in progress |
| evt_done | input | 1 | Transaction done pulse |
| evt_done_nostop | input | 1 | Transaction done without stop pulse |
| evt_arb_lost | input | 1 | Arbitration lost pulse |
| evt_bus_err | input | 1 | Bus error pulse |
| mask_wr | input | 1 | Load the mask register |
| mask_wdata | input | 32 | New mask value |
| clr_wr | input | 1 | Clear write strobe |
| clr_wdata | input | 32 | Ones select sticky bits to clear |
| raw_status | output | 32 | Raw interrupt status |
| masked_status | output | 32 | Raw status ANDed with mask |
| irq | output | 1 | Interrupt line |

## Verification
Each queue is filled one byte at a time from empty to full and then drained. After every step the whole status word is compared with a value computed arithmetically from the count. This is repeated for several thresholds, including zero, the largest legal value and values that must be clamped, so an off-by-one in either comparison or in the clamp shows up at a specific count. Pushes into a full queue, pops from an empty one and accesses during a flush separate dropped operations from ones that were wrongly accepted. A sweep of a one-hot mask over all 32 bits, with the sticky events set, ties every status bit to the interrupt line. A clear that coincides with an event checks the priority between setting and clearing a bit.

// File: rtl/i2c_fifo_irq.sv
module i2c_fifo_irq #(
  parameter int DEPTH     = 16,
  parameter int FLUSH_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_tx_wr,
  input  logic [7:0]  sw_tx_data,
  input  logic        sw_rx_rd,
  output logic [7:0]  sw_rx_data,
  input  logic        eng_tx_pull,
  output logic [7:0]  eng_tx_data,
  output logic        eng_tx_valid,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_data,
  output logic        eng_rx_ready,
  input  logic [7:0]  tx_thr,
  input  logic [7:0]  rx_thr,
  input  logic        flush_tx_req,
  input  logic        flush_rx_req,
  output logic        flush_tx_busy,
  output logic        flush_rx_busy,
  input  logic        evt_done,
  input  logic        evt_done_nostop,
  input  logic        evt_arb_lost,
  input  logic        evt_bus_err,
  input  logic        mask_wr,
  input  logic [31:0] mask_wdata,
  input  logic        clr_wr,
  input  logic [31:0] clr_wdata,
  output logic [31:0] raw_status,
  output logic [31:0] masked_status,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int FW = $clog2(FLUSH_CYC + 1);
  localparam logic [7:0]  MAXT     = 8'(DEPTH / 2 - 1);
  localparam logic [CW-1:0] FULL   = CW'(DEPTH);
  localparam logic [31:0] CLR_OK   = 32'h131F_007F;
  localparam logic [31:0] MASK_OK  = 32'h1FFF_FFFF;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [FW-1:0] tx_fc, rx_fc;
  logic [31:0]   stk, mask_q, set_vec, clr_vec;
  logic [7:0]    tx_t, rx_t;

  assign flush_tx_busy = tx_fc != '0;
  assign flush_rx_busy = rx_fc != '0;

  wire tx_blk  = flush_tx_busy || flush_tx_req;
  wire rx_blk  = flush_rx_busy || flush_rx_req;
  wire tx_push = sw_tx_wr && !tx_blk && tx_cnt != FULL;
  wire tx_pop  = eng_tx_pull && !tx_blk && tx_cnt != '0;
  wire rx_push = eng_rx_push && !rx_blk && rx_cnt != FULL;
  wire rx_pop  = sw_rx_rd && !rx_blk && rx_cnt != '0;
  wire tx_ovr  = sw_tx_wr && !tx_blk && tx_cnt == FULL;

  assign eng_tx_valid = tx_cnt != '0;
  assign eng_rx_ready = rx_cnt != FULL && !flush_rx_busy;
  assign eng_tx_data  = eng_tx_valid ? tx_mem[tx_rp] : 8'h00;
  assign sw_rx_data   = rx_cnt != '0 ? rx_mem[rx_rp] : 8'h00;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= sw_tx_data;
    if (rx_push) rx_mem[rx_wp] <= eng_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0; tx_fc <= '0;
    end else if (flush_tx_req) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0; tx_fc <= FW'(FLUSH_CYC);
    end else begin
      if (flush_tx_busy) tx_fc <= tx_fc - 1'b1;
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0; rx_fc <= '0;
    end else if (flush_rx_req) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0; rx_fc <= FW'(FLUSH_CYC);
    end else begin
      if (flush_rx_busy) rx_fc <= rx_fc - 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_comb begin
    set_vec     = '0;
    set_vec[3]  = tx_ovr;
    set_vec[19] = evt_done;
    set_vec[28] = evt_done_nostop;
    set_vec[24] = evt_arb_lost;
    set_vec[25] = evt_bus_err;
  end

  assign clr_vec = clr_wr ? (clr_wdata & CLR_OK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk    <= '0;
      mask_q <= '0;
    end else begin
      stk <= (stk & ~clr_vec) | set_vec;
      if (mask_wr) mask_q <= mask_wdata & MASK_OK;
    end
  end

  assign tx_t = tx_thr > MAXT ? MAXT : tx_thr;
  assign rx_t = rx_thr > MAXT ? MAXT : rx_thr;

  always_comb begin
    raw_status    = stk;
    raw_status[0] = tx_cnt == '0;
    raw_status[1] = 8'(tx_cnt) <= tx_t;
    raw_status[2] = tx_cnt == FULL;
    raw_status[4] = rx_cnt == '0;
    raw_status[5] = 8'(rx_cnt) >= rx_t;
    raw_status[6] = rx_cnt == FULL;
  end

  assign masked_status = raw_status & mask_q;
  assign irq           = masked_status != '0;
endmodule

module i2c_fifo_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_tx_wr,
  input logic        flush_tx_req,
  input logic        flush_tx_busy,
  input logic        flush_rx_req,
  input logic        flush_rx_busy,
  input logic        evt_done,
  input logic        evt_arb_lost,
  input logic        clr_wr,
  input logic [31:0] clr_wdata,
  input logic [31:0] raw_status
);
  a_r3_not_empty_and_full: assert property (@(posedge clk) disable iff (!rst_n)
    !(raw_status[0] && raw_status[2]));
  a_r4_not_empty_and_full: assert property (@(posedge clk) disable iff (!rst_n)
    !(raw_status[4] && raw_status[6]));
  a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_tx_wr && raw_status[2] && !flush_tx_busy && !flush_tx_req) |=> raw_status[3]);
  a_r8_done_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> raw_status[19]);
  a_r9_clear_arb: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_wdata[24] && !evt_arb_lost) |=> !raw_status[24]);
  a_r11_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_tx_req |=> (raw_status[0] && flush_tx_busy));
  a_r11_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_rx_req |=> (raw_status[4] && flush_rx_busy));
endmodule

bind i2c_fifo_irq i2c_fifo_irq_chk u_chk (.*);

// File: tb/sim_i2c_fifo_irq.sv
module sim_i2c_fifo_irq;
  localparam int D  = 16;
  localparam int FC = 4;
  localparam int MT = D / 2 - 1;

  logic clk = 0, rst_n = 0;
  logic sw_tx_wr = 0, sw_rx_rd = 0, eng_tx_pull = 0, eng_rx_push = 0;
  logic [7:0] sw_tx_data = 0, eng_rx_data = 0, tx_thr = 1, rx_thr = 8;
  logic [7:0] sw_rx_data, eng_tx_data;
  logic eng_tx_valid, eng_rx_ready, flush_tx_busy, flush_rx_busy, irq;
  logic flush_tx_req = 0, flush_rx_req = 0;
  logic evt_done = 0, evt_done_nostop = 0, evt_arb_lost = 0, evt_bus_err = 0;
  logic mask_wr = 0, clr_wr = 0;
  logic [31:0] mask_wdata = 0, clr_wdata = 0, raw_status, masked_status;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] txq[$], rxq[$];
  logic [31:0] m_stk = 0, m_mask = 0;

  always #2 clk = ~clk;

  i2c_fifo_irq #(.DEPTH(D), .FLUSH_CYC(FC)) u0 (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_raw();
    logic [31:0] r;
    int tt, rt;
    tt = tx_thr > MT ? MT : int'(tx_thr);
    rt = rx_thr > MT ? MT : int'(rx_thr);
    r = m_stk;
    r[0] = txq.size() == 0;
    r[1] = txq.size() <= tt;
    r[2] = txq.size() == D;
    r[4] = rxq.size() == 0;
    r[5] = rxq.size() >= rt;
    r[6] = rxq.size() == D;
    return r;
  endfunction

  task automatic check_raw(string tag);
    logic [31:0] e;
    e = exp_raw();
    chk(tag, raw_status, e);
    chk({tag, " masked R10"}, masked_status, e & m_mask);
    chk({tag, " irq R10"}, 32'(irq), 32'((e & m_mask) != 0));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_tx(logic [7:0] b);
    sw_tx_wr = 1; sw_tx_data = b; tick(); sw_tx_wr = 0;
    if (txq.size() < D) txq.push_back(b); else m_stk[3] = 1;
  endtask

  task automatic pull_tx();
    logic [7:0] e;
    e = txq.size() ? txq[0] : 8'h00;
    chk("R2 tx order", 32'(eng_tx_data), 32'(e));
    eng_tx_pull = 1; tick(); eng_tx_pull = 0;
    if (txq.size()) void'(txq.pop_front());
  endtask

  task automatic push_rx(logic [7:0] b);
    eng_rx_push = 1; eng_rx_data = b; tick(); eng_rx_push = 0;
    if (rxq.size() < D) rxq.push_back(b);
  endtask

  task automatic pop_rx();
    logic [7:0] e;
    e = rxq.size() ? rxq[0] : 8'h00;
    chk("R2 rx order", 32'(sw_rx_data), 32'(e));
    sw_rx_rd = 1; tick(); sw_rx_rd = 0;
    if (rxq.size()) void'(rxq.pop_front());
  endtask

  task automatic do_flush(bit is_tx);
    if (is_tx) flush_tx_req = 1; else flush_rx_req = 1;
    tick();
    flush_tx_req = 0; flush_rx_req = 0;
    if (is_tx) txq.delete(); else rxq.delete();
    for (int i = 0; i < FC; i++) begin
      chk("R11 busy", 32'(is_tx ? flush_tx_busy : flush_rx_busy), 1);
      if (is_tx) sw_tx_wr = 1; else eng_rx_push = 1;
      tick();
      sw_tx_wr = 0; eng_rx_push = 0;
    end
    chk("R11 busy drop", 32'(is_tx ? flush_tx_busy : flush_rx_busy), 0);
    check_raw("R11 empty after flush");
  endtask

  task automatic write_mask(logic [31:0] v);
    mask_wr = 1; mask_wdata = v; tick(); mask_wr = 0;
    m_mask = v & 32'h1FFF_FFFF;
  endtask

  task automatic clear(logic [31:0] v);
    clr_wr = 1; clr_wdata = v; tick(); clr_wr = 0;
    m_stk = m_stk & ~(v & 32'h131F_007F);
  endtask

  initial begin
    int tthr[4] = '{0, 3, 7, 12};
    int rthr[4] = '{0, 1, 8, 15};
    #11; rst_n = 1;
    @(negedge clk);
    check_raw("R1 reset");
    chk("R1 busy", {30'd0, flush_tx_busy, flush_rx_busy}, 0);

    foreach (tthr[k]) begin
      tx_thr = 8'(tthr[k]);
      do_flush(1);
      for (int i = 0; i < D; i++) begin
        push_tx(8'(i * 7 + k + 3));
        check_raw(tthr[k] > MT ? "R5 tx clamp" : "R3 tx levels");
      end
      push_tx(8'hEE);
      check_raw("R6 overrun");
      for (int i = 0; i < D; i++) begin
        pull_tx();
        check_raw(tthr[k] > MT ? "R5 tx clamp" : "R3 tx drain");
      end
      chk("R7 tx valid low", 32'(eng_tx_valid), 0);
      pull_tx();
      check_raw("R7 tx pull empty");
      clear(32'hFFFF_FFFF);
      check_raw("R9 clear overrun");
    end

    foreach (rthr[k]) begin
      rx_thr = 8'(rthr[k]);
      do_flush(0);
      for (int i = 0; i < D; i++) begin
        push_rx(8'(i * 11 + k + 1));
        check_raw(rthr[k] > MT ? "R5 rx clamp" : "R4 rx levels");
      end
      chk("R7 rx ready low", 32'(eng_rx_ready), 0);
      push_rx(8'h5A);
      check_raw("R7 rx full push");
      for (int i = 0; i < D; i++) begin
        pop_rx();
        check_raw(rthr[k] > MT ? "R5 rx clamp" : "R4 rx drain");
      end
      pop_rx();
      check_raw("R7 rx pop empty");
    end

    push_tx(8'h21); push_rx(8'h42);
    evt_done = 1; tick(); evt_done = 0; m_stk[19] = 1; check_raw("R8 done");
    evt_done_nostop = 1; tick(); evt_done_nostop = 0; m_stk[28] = 1; check_raw("R8 nostop");
    evt_arb_lost = 1; tick(); evt_arb_lost = 0; m_stk[24] = 1; check_raw("R8 arb");
    evt_bus_err = 1; tick(); evt_bus_err = 0; m_stk[25] = 1; check_raw("R8 berr");
    tick(); tick();
    check_raw("R8 sticky hold");
    for (int b = 0; b < 32; b++) begin
      write_mask(32'h1 << b);
      check_raw("R10 mask sweep");
    end
    write_mask(32'hFFFF_FFFF);
    check_raw("R10 all mask");
    clr_wr = 1; clr_wdata = 32'hFFFF_FFFF; evt_arb_lost = 1; tick();
    clr_wr = 0; evt_arb_lost = 0;
    m_stk = 32'h0100_0000;
    check_raw("R9 set wins");
    clear(32'h0100_0000);
    check_raw("R9 clear level untouched");
    write_mask(32'h0);
    check_raw("R10 mask zero");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule